// File: doc/BRIEF.md
# Rotating Shifter Operand Generator

This unit forms the second source operand of a data-processing instruction, together with the carry bit that a rotate yields. It is purely combinational. It sits between the register read ports and the ALU. The instruction word, the value of the operand register, the value of the shift-amount register and the current carry flag all arrive already resolved. Register selection, the ALU and the flag update are done elsewhere.

A two-bit form select picks one of three addressing forms:

- **Rotated immediate.** An 8-bit constant is rotated by an even amount.
- **Register rotated by a constant.** A register is rotated by a 5-bit constant. A constant of zero means a one-place rotate through the carry flag.
- **Register rotated by a register.** A register is rotated by an amount read from the low byte of a second register.

Every form has its own rule for the carry-out. Those rules, and what happens when the rotate amount is zero or wraps to zero, are the main content of this unit.

Top module: `rot_operand_gen`

## Requirements
- R1: With `form_sel` = 2'b00, `operand_out` equals `instr[7:0]` zero-extended to 32 bits and rotated right by twice the value of `instr[11:8]`.
- R2: With `form_sel` = 2'b00:
  - when `instr[11:8]` is zero, `carry_out` equals `carry_in`;
  - otherwise, `carry_out` equals bit 31 of `operand_out`.
- R3: With `form_sel` = 2'b01 and n = `instr[11:7]` nonzero:
  - `operand_out` is `opnd_val` rotated right by n;
  - `carry_out` is `opnd_val[n-1]`.
- R4: With `form_sel` = 2'b01 and `instr[11:7]` zero:
  - `operand_out` is `{carry_in, opnd_val[31:1]}`;
  - `carry_out` is `opnd_val[0]`.
- R5: With `form_sel` = 2'b10 and `shamt_val[7:0]` zero, `operand_out` equals `opnd_val` and `carry_out` equals `carry_in`.
- R6: With `form_sel` = 2'b10, `shamt_val[7:0]` nonzero and `shamt_val[4:0]` zero, `operand_out` equals `opnd_val` and `carry_out` equals `opnd_val[31]`.
- R7: With `form_sel` = 2'b10 and n = `shamt_val[4:0]` nonzero:
  - `operand_out` is `opnd_val` rotated right by n;
  - `carry_out` is `opnd_val[n-1]`.
- R8: With `form_sel` = 2'b11, `operand_out` is zero and `carry_out` equals `carry_in`.
- R9: `instr[31:12]` and `shamt_val[31:8]` have no effect on either output in any form.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| form_sel | input | 2 | Form select: 00 immediate, 01 register by constant, 10 register by register, 11 unused |
| instr | input | 32 | Instruction word |
| opnd_val | input | 32 | Value of the operand register |
| shamt_val | input | 32 | Value of the shift-amount register |
| carry_in | input | 1 | Current carry flag |
| operand_out | output | 32 | Generated operand |
| carry_out | output | 1 | Shifter carry-out |

## Verification
The bench goes after the zero cases, because each of them uses a different rule.

- **Immediate with a zero rotate field.** A design that took bit 31 here would lose the incoming carry.
- **Constant amount of zero.** A design that treated this as no rotate would skip the rotate-through-carry.
- **Register amount with a zero low byte.** This case must pass the old carry through.
- **Register amount that is a nonzero multiple of 32** (0x20, 0x40, 0xE0). This case must give bit 31. A design that looked only at the low five bits would return the old flag instead.

Rotates by 1 and by 31 catch an off-by-one in the carry bit index. Random words with the high bits of the instruction and of the shift register flipped show whether those bits leak into the result.

// File: rtl/rog_pkg.sv
package rog_pkg;

  localparam int WORD_W    = 32;
  localparam int IMM_W     = 8;
  localparam int IMM_ROT_W = 4;
  localparam int SH_W      = $clog2(WORD_W);
  localparam int AMT_BYTE  = 8;

  typedef enum logic [1:0] {
    FORM_IMM     = 2'b00,
    FORM_REG_IMM = 2'b01,
    FORM_REG_REG = 2'b10,
    FORM_NONE    = 2'b11
  } form_e;

  typedef struct packed {
    logic              carry;
    logic [WORD_W-1:0] value;
  } shres_t;

endpackage

// File: rtl/rog_barrel_ror.sv
module rog_barrel_ror #(
  parameter int W   = 32,
  localparam int AW = $clog2(W)
) (
  input  logic [W-1:0]  data_i,
  input  logic [AW-1:0] amt_i,
  output logic [W-1:0]  data_o
);

  logic [W-1:0] stage [0:AW];

  assign stage[0] = data_i;

  for (genvar k = 0; k < AW; k++) begin : g_stage
    localparam int S = 2 ** k;
    always_comb begin
      if (amt_i[k]) stage[k+1] = {stage[k][S-1:0], stage[k][W-1:S]};
      else          stage[k+1] = stage[k];
    end
  end

  assign data_o = stage[AW];

endmodule

// File: rtl/rog_imm_path.sv
module rog_imm_path
  import rog_pkg::*;
(
  input  logic [IMM_W-1:0]     imm_i,
  input  logic [IMM_ROT_W-1:0] rot_i,
  input  logic                 carry_i,
  output shres_t               res_o
);

  logic [WORD_W-1:0] imm_ext;
  logic [SH_W-1:0]   amt;
  logic [WORD_W-1:0] rotated;

  assign imm_ext = {{(WORD_W-IMM_W){1'b0}}, imm_i};
  assign amt     = {rot_i, 1'b0};

  rog_barrel_ror #(.W(WORD_W)) i_ror (
    .data_i (imm_ext),
    .amt_i  (amt),
    .data_o (rotated)
  );

  always_comb begin
    res_o.value = rotated;
    if (rot_i == '0) res_o.carry = carry_i;
    else             res_o.carry = rotated[WORD_W-1];
  end

endmodule

// File: rtl/rog_regimm_path.sv
module rog_regimm_path
  import rog_pkg::*;
(
  input  logic [WORD_W-1:0] opnd_i,
  input  logic [SH_W-1:0]   amt_i,
  input  logic              carry_i,
  output shres_t            res_o
);

  logic [WORD_W-1:0] rotated;

  rog_barrel_ror #(.W(WORD_W)) i_ror (
    .data_i (opnd_i),
    .amt_i  (amt_i),
    .data_o (rotated)
  );

  always_comb begin
    if (amt_i == '0) begin
      res_o.value = {carry_i, opnd_i[WORD_W-1:1]};
      res_o.carry = opnd_i[0];
    end else begin
      res_o.value = rotated;
      res_o.carry = rotated[WORD_W-1];
    end
  end

endmodule

// File: rtl/rog_regreg_path.sv
module rog_regreg_path
  import rog_pkg::*;
(
  input  logic [WORD_W-1:0]   opnd_i,
  input  logic [AMT_BYTE-1:0] amt_byte_i,
  input  logic                carry_i,
  output shres_t              res_o
);

  logic [SH_W-1:0]   amt_low;
  logic [WORD_W-1:0] rotated;
  logic              byte_zero;
  logic              low_zero;

  assign amt_low   = amt_byte_i[SH_W-1:0];
  assign byte_zero = (amt_byte_i == '0);
  assign low_zero  = (amt_low == '0);

  rog_barrel_ror #(.W(WORD_W)) i_ror (
    .data_i (opnd_i),
    .amt_i  (amt_low),
    .data_o (rotated)
  );

  always_comb begin
    res_o.value = rotated;
    if (byte_zero)     res_o.carry = carry_i;
    else if (low_zero) res_o.carry = opnd_i[WORD_W-1];
    else               res_o.carry = rotated[WORD_W-1];
  end

endmodule

// File: rtl/rot_operand_gen.sv
module rot_operand_gen
  import rog_pkg::*;
(
  input  logic [1:0]        form_sel,
  input  logic [WORD_W-1:0] instr,
  input  logic [WORD_W-1:0] opnd_val,
  input  logic [WORD_W-1:0] shamt_val,
  input  logic              carry_in,
  output logic [WORD_W-1:0] operand_out,
  output logic              carry_out
);

  localparam int IMM_ROT_LSB = IMM_W;
  localparam int REG_AMT_LSB = IMM_W - 1;

  shres_t res_imm;
  shres_t res_regimm;
  shres_t res_regreg;
  shres_t res_sel;
  form_e  form;

  logic unused_upper_bits;
  assign unused_upper_bits = ^{instr[WORD_W-1:IMM_W+IMM_ROT_W],
                               shamt_val[WORD_W-1:AMT_BYTE]};

  assign form = form_e'(form_sel);

  rog_imm_path i_imm (
    .imm_i   (instr[IMM_W-1:0]),
    .rot_i   (instr[IMM_ROT_LSB +: IMM_ROT_W]),
    .carry_i (carry_in),
    .res_o   (res_imm)
  );

  rog_regimm_path i_regimm (
    .opnd_i  (opnd_val),
    .amt_i   (instr[REG_AMT_LSB +: SH_W]),
    .carry_i (carry_in),
    .res_o   (res_regimm)
  );

  rog_regreg_path i_regreg (
    .opnd_i     (opnd_val),
    .amt_byte_i (shamt_val[AMT_BYTE-1:0]),
    .carry_i    (carry_in),
    .res_o      (res_regreg)
  );

  always_comb begin
    unique case (form)
      FORM_IMM:     res_sel = res_imm;
      FORM_REG_IMM: res_sel = res_regimm;
      FORM_REG_REG: res_sel = res_regreg;
      default: begin
        res_sel.value = '0;
        res_sel.carry = carry_in;
      end
    endcase
  end

  assign operand_out = res_sel.value;
  assign carry_out   = res_sel.carry;

endmodule

// File: rtl/rog_checker.sv
module rog_checker
  import rog_pkg::*;
(
  input logic [1:0]        form_sel,
  input logic [WORD_W-1:0] instr,
  input logic [WORD_W-1:0] opnd_val,
  input logic [WORD_W-1:0] shamt_val,
  input logic              carry_in,
  input logic [WORD_W-1:0] operand_out,
  input logic              carry_out
);

  logic unused_chk_bits;
  assign unused_chk_bits = ^{instr[WORD_W-1:12], shamt_val[WORD_W-1:8]};

  always_comb begin
    // R1: a rotate keeps the number of set bits of the immediate
    if (form_sel == 2'b00)
      assert_imm_popcount_R1:
        assert ($countones(operand_out) == $countones(instr[7:0]));

    // R2: a zero rotate field gives the bare immediate and the old carry
    if (form_sel == 2'b00 && instr[11:8] == 4'd0)
      assert_imm_zero_rot_R2:
        assert (operand_out == {24'd0, instr[7:0]} && carry_out == carry_in);

    // R3: a rotate keeps the number of set bits of the register
    if (form_sel == 2'b01 && instr[11:7] != 5'd0)
      assert_regimm_popcount_R3:
        assert ($countones(operand_out) == $countones(opnd_val));

    // R4: a zero constant rotates one place through the carry
    if (form_sel == 2'b01 && instr[11:7] == 5'd0)
      assert_regimm_extend_R4:
        assert (carry_out == opnd_val[0] && operand_out[31] == carry_in
                && operand_out[30:0] == opnd_val[31:1]);

    // R5: a zero low byte passes operand and carry through
    if (form_sel == 2'b10 && shamt_val[7:0] == 8'd0)
      assert_regreg_zero_R5:
        assert (operand_out == opnd_val && carry_out == carry_in);

    // R6: a nonzero multiple of 32 gives the top bit as carry
    if (form_sel == 2'b10 && shamt_val[7:0] != 8'd0 && shamt_val[4:0] == 5'd0)
      assert_regreg_wrap_R6:
        assert (operand_out == opnd_val && carry_out == opnd_val[31]);

    // R7: a rotate keeps the bit count, and the carry is the new top bit
    if (form_sel == 2'b10 && shamt_val[4:0] != 5'd0)
      assert_regreg_rot_R7:
        assert ($countones(operand_out) == $countones(opnd_val)
                && carry_out == operand_out[31]);

    // R8: the unused select code gives zero and the old carry
    if (form_sel == 2'b11)
      assert_unused_form_R8:
        assert (operand_out == '0 && carry_out == carry_in);
  end

endmodule

bind rot_operand_gen rog_checker i_rog_checker (.*);

// File: tb/test_rot_operand_gen.sv
module test_rot_operand_gen;

  logic        clk;
  logic [1:0]  form_sel;
  logic [31:0] instr;
  logic [31:0] opnd_val;
  logic [31:0] shamt_val;
  logic        carry_in;
  logic [31:0] operand_out;
  logic        carry_out;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  rot_operand_gen i_rot_operand_gen (
    .form_sel    (form_sel),
    .instr       (instr),
    .opnd_val    (opnd_val),
    .shamt_val   (shamt_val),
    .carry_in    (carry_in),
    .operand_out (operand_out),
    .carry_out   (carry_out)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual=%0d cycles expected<=100000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic [31:0] ror32(input logic [31:0] v, input int n);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = v[(i + n) % 32];
    return r;
  endfunction

  function automatic logic [32:0] model(input logic [1:0] f, input logic [31:0] ins,
                                        input logic [31:0] ov, input logic [31:0] sv,
                                        input logic c);
    logic [31:0] v;
    logic        co;
    int          n;
    case (f)
      2'b00: begin
        n = 2 * int'(ins[11:8]);
        v = ror32({24'd0, ins[7:0]}, n);
        co = (n == 0) ? c : v[31];
      end
      2'b01: begin
        n = int'(ins[11:7]);
        if (n == 0) begin
          v = {c, ov[31:1]};
          co = ov[0];
        end else begin
          v = ror32(ov, n);
          co = ov[n-1];
        end
      end
      2'b10: begin
        n = int'(sv[4:0]);
        if (sv[7:0] == 8'd0) begin
          v = ov;
          co = c;
        end else if (n == 0) begin
          v = ov;
          co = ov[31];
        end else begin
          v = ror32(ov, n);
          co = ov[n-1];
        end
      end
      default: begin
        v = 32'd0;
        co = c;
      end
    endcase
    return {co, v};
  endfunction

  function automatic string req_of(input logic [1:0] f, input logic [31:0] ins,
                                   input logic [31:0] sv);
    case (f)
      2'b00:   return "R1/R2";
      2'b01:   return (ins[11:7] == 5'd0) ? "R4" : "R3";
      2'b10:   return (sv[7:0] == 8'd0) ? "R5" : (sv[4:0] == 5'd0) ? "R6" : "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic apply(input logic [1:0] f, input logic [31:0] ins,
                       input logic [31:0] ov, input logic [31:0] sv, input logic c);
    @(negedge clk);
    form_sel  = f;
    instr     = ins;
    opnd_val  = ov;
    shamt_val = sv;
    carry_in  = c;
    @(posedge clk);
    #1;
  endtask

  task automatic check_vec(input logic [1:0] f, input logic [31:0] ins,
                           input logic [31:0] ov, input logic [31:0] sv, input logic c);
    logic [32:0] exp;
    exp = model(f, ins, ov, sv, c);
    apply(f, ins, ov, sv, c);
    checks = checks + 1;
    if ({carry_out, operand_out} !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual op=%h c=%b expected op=%h c=%b",
               req_of(f, ins, sv), operand_out, carry_out, exp[31:0], exp[32]);
    end
  endtask

  // R9: flipping ignored high bits must not change the outputs
  task automatic check_r9(input logic [1:0] f, input logic [31:0] ins,
                          input logic [31:0] ov, input logic [31:0] sv, input logic c,
                          input logic [19:0] ins_flip, input logic [23:0] sv_flip);
    logic [32:0] first;
    apply(f, ins, ov, sv, c);
    first = {carry_out, operand_out};
    apply(f, ins ^ {ins_flip, 12'd0}, ov, sv ^ {sv_flip, 8'd0}, c);
    checks = checks + 1;
    if ({carry_out, operand_out} !== first) begin
      errors = errors + 1;
      $display("FAIL R9: actual op=%h c=%b expected op=%h c=%b",
               operand_out, carry_out, first[31:0], first[32]);
    end
  endtask

  initial begin
    form_sel = 2'b00; instr = '0; opnd_val = '0; shamt_val = '0; carry_in = 1'b0;
    void'($urandom(32'd20240611));
    @(posedge clk);
    #1;
    checks = checks + 1;
    if (operand_out !== 32'd0 || carry_out !== 1'b0) begin
      errors = errors + 1;
      $display("FAIL R1 idle: actual op=%h c=%b expected op=0 c=0", operand_out, carry_out);
    end

    // R1, R2: immediate form
    check_vec(2'b00, 32'h0000_00FF, 32'h0, 32'h0, 1'b1);   // R2 zero rotate, carry kept
    check_vec(2'b00, 32'h0000_04FF, 32'h0, 32'h0, 1'b0);   // R1 ror 8 -> FF000000, carry 1
    check_vec(2'b00, 32'h0000_0101, 32'h0, 32'h0, 1'b1);   // R1 ror 2 -> 40000000, carry 0
    check_vec(2'b00, 32'h0000_0F81, 32'h0, 32'h0, 1'b0);   // R1 ror 30
    // R3, R4: register rotated by constant
    check_vec(2'b01, 32'h0000_0000, 32'h0000_0001, 32'h0, 1'b1); // R4 -> 80000000 c1
    check_vec(2'b01, 32'h0000_0000, 32'hFFFF_FFFE, 32'h0, 1'b0); // R4 -> 7FFFFFFF c0
    check_vec(2'b01, 32'h0000_0080, 32'h0000_0001, 32'h0, 1'b0); // R3 n=1
    check_vec(2'b01, 32'h0000_0F80, 32'h4000_0000, 32'h0, 1'b0); // R3 n=31
    // R5, R6, R7: register rotated by register
    check_vec(2'b10, 32'h0, 32'h8000_0001, 32'h0000_0100, 1'b1); // R5 low byte zero
    check_vec(2'b10, 32'h0, 32'h8000_0001, 32'h0000_0000, 1'b0); // R5
    check_vec(2'b10, 32'h0, 32'h8000_0000, 32'h0000_0020, 1'b0); // R6 32
    check_vec(2'b10, 32'h0, 32'h7FFF_FFFF, 32'h0000_0040, 1'b1); // R6 64
    check_vec(2'b10, 32'h0, 32'h8000_0000, 32'h0000_00E0, 1'b0); // R6 224
    check_vec(2'b10, 32'h0, 32'h0000_0001, 32'h0000_0021, 1'b0); // R7 n=1
    check_vec(2'b10, 32'h0, 32'h4000_0000, 32'hFFFF_FF1F, 1'b0); // R7 n=31
    // R8: unused select
    check_vec(2'b11, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h1, 1'b1);
    check_vec(2'b11, 32'h1234_5678, 32'hDEAD_BEEF, 32'h3, 1'b0);

    // R9 directed and random
    for (int f = 0; f < 4; f++)
      check_r9(2'(f), 32'h0000_0A5C, 32'hC001_D00D, 32'h0000_0017, 1'b1,
               20'hFFFFF, 24'hFFFFFF);

    for (int i = 0; i < 3000; i++) begin
      logic [1:0]  f;
      logic [31:0] ins, ov, sv;
      logic        c;
      f   = 2'($urandom_range(0, 3));
      ins = $urandom();
      ov  = $urandom();
      sv  = $urandom();
      c   = 1'($urandom());
      if (i % 5 == 0) sv[7:0] = 8'($urandom_range(0, 7) << 5);
      if (i % 7 == 0) ins[11:7] = 5'd0;
      check_vec(f, ins, ov, sv, c);
      if (i % 10 == 0)
        check_r9(f, ins, ov, sv, c, 20'($urandom()), 24'($urandom()));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule